// File: doc/BRIEF.md
# Pipelined Mersenne Twister Random Word Generator

This block produces a stream of 32-bit uniformly distributed pseudorandom words using the 19937-bit twisted generalized feedback recurrence. It returns one word per clock once it is running. A single 32-bit seed is presented together with a one-cycle load strobe. The block then expands that seed into a 624-word state pool at one word per cycle. After that it enters a steady loop in which each state word is rewritten in place from three older words and the freshly written word is tempered into an output value.

The state is stored three times, once in each of three one-read/one-write memories. Every new word goes into all three copies in the same cycle, so each copy can serve one of the three reads an update needs. The update path has four stages: address issue, memory read, twist, and write-back select. The tempering register works in parallel with the write-back.

The output is a valid/ready stream. A word is transferred on a rising edge where `rnd_valid` and `rnd_ready` are both high. While `rnd_valid` is high and `rnd_ready` is low, the whole pipeline freezes and the presented word stays unchanged. A load strobe at any time discards whatever is in flight and restarts the seeding.

Top module: `twister_rng`

## Requirements
- R1: After reset, and until the first load strobe, `rnd_valid` stays low.
- R2: When the load strobe is sampled on clock edge 0, `rnd_valid` stays low through edge 626 and is high after edge 627 (state size + 3).
- R3: Seed expansion: word 0 is the seed, and word j = 1812433253 × (word[j-1] XOR (word[j-1] >> 30)) + j, modulo 2^32, for j = 1..623.
- R4: Update k (k = 0,1,2,…) rewrites index i = k mod 624. It takes bit 31 of word i and bits 30..0 of word (i+1) mod 624 into a value y. The new word i is word (i+397) mod 624 XOR (y >> 1), XORed with 0x9908B0DF when bit 0 of y is 1.
- R5: Each output is the tempered form of the newly written word: y ^= y>>11; y ^= (y<<7) & 0x9D2C5680; y ^= (y<<15) & 0xEFC60000; y ^= y>>18.
- R6: With seed 5489, the first output word is 3499211612.
- R7: While `rnd_ready` is held high, once the first word has appeared, `rnd_valid` stays high on every cycle and a new word is delivered on every edge.
- R8: While `rnd_valid` is high and `rnd_ready` is low, `rnd_valid` and `rnd_data` hold their values. No word is lost or repeated across a stall.
- R9: A load strobe during output clears `rnd_valid` on the next edge. The words that follow are the sequence of the new seed, starting from its first word.
- R10: A load strobe during seeding restarts the expansion from the newer seed, and the R2 latency is counted from that newer strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_in | input | 32 | Seed value, sampled with the load strobe |
| seed_load | input | 1 | One-cycle strobe that starts seeding |
| rnd_data | output | 32 | Tempered random word |
| rnd_valid | output | 1 | Output word is valid |
| rnd_ready | input | 1 | Consumer accepts the word on this edge |

## Verification
The only timed result is the first word after a strobe. It is due after edge 627: 624 seeding writes, then the issue, read and twist registers, then the output register. The bench counts falling edges from the strobe edge and requires `rnd_valid` low at every one before that point and high exactly at it. After that, every word is due on the edge after an accepted transfer. The bench sets `rnd_ready` on each falling edge, then samples the outputs on the same falling edge. It compares a word with the arithmetic reference only when that word is accepted, and it requires a stalled word to reappear unchanged on the next falling edge.

// File: rtl/twister_pkg.sv
package twister_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t TWIST_XOR = 32'h9908_B0DF;
  localparam word_t TMP_MASK_B = 32'h9D2C_5680;
  localparam word_t TMP_MASK_C = 32'hEFC6_0000;
  localparam word_t EXP_MUL    = 32'd1812433253;

  typedef enum logic [1:0] {PH_IDLE, PH_SEED, PH_RUN} phase_t;

  // Seed expansion step: previous word and index of the word being made.
  function automatic word_t expand_step(word_t prev, word_t j);
    word_t mixed;
    mixed = prev ^ (prev >> 30);
    return word_t'(EXP_MUL * mixed) + j;
  endfunction

  // Recurrence: current word, following word, far word.
  function automatic word_t twist_word(word_t w_cur, word_t w_nxt, word_t w_far);
    word_t y;
    y = {w_cur[WORD_W-1], w_nxt[WORD_W-2:0]};
    return w_far ^ (y >> 1) ^ (y[0] ? TWIST_XOR : '0);
  endfunction

  function automatic word_t temper(word_t x);
    word_t y;
    y = x;
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & TMP_MASK_B);
    y = y ^ ((y << 15) & TMP_MASK_C);
    y = y ^ (y >> 18);
    return y;
  endfunction
endpackage

// File: rtl/twister_state_ram.sv
module twister_state_ram
  import twister_pkg::*;
#(
  parameter int unsigned DEPTH = 624,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/twister_seed_ctl.sv
module twister_seed_ctl
  import twister_pkg::*;
#(
  parameter int unsigned DEPTH = 624,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_load,
  input  word_t         seed_val,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output word_t         wr_data,
  output logic          running
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  phase_t        phase;
  logic [AW-1:0] j_q;
  word_t         cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      j_q   <= '0;
      cur_q <= '0;
    end else if (seed_load) begin
      phase <= PH_SEED;
      j_q   <= '0;
      cur_q <= seed_val;
    end else if (phase == PH_SEED) begin
      cur_q <= expand_step(cur_q, word_t'(j_q) + 32'd1);
      j_q   <= j_q + 1'b1;
      if (j_q == LAST) phase <= PH_RUN;
    end
  end

  assign wr_en   = (phase == PH_SEED);
  assign wr_addr = j_q;
  assign wr_data = cur_q;
  assign running = (phase == PH_RUN);
endmodule

// File: rtl/twister_update_pipe.sv
module twister_update_pipe
  import twister_pkg::*;
#(
  parameter int unsigned DEPTH  = 624,
  parameter int unsigned OFFSET = 397,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          running,
  input  logic          adv,
  input  word_t         q_cur,
  input  word_t         q_nxt,
  input  word_t         q_far,
  output logic          rd_en,
  output logic [AW-1:0] a_cur,
  output logic [AW-1:0] a_nxt,
  output logic [AW-1:0] a_far,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output word_t         wb_data
);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_X = (AW+1)'(DEPTH);
  localparam logic [AW:0]   OFF_X   = (AW+1)'(OFFSET);

  logic [AW-1:0] idx_q;   // stage 1: next index to issue
  logic [AW-1:0] idx_rd;  // stage 2: index whose words sit in the RAM registers
  logic          v_rd;
  logic [AW:0]   sum_far;

  always_comb begin
    a_cur   = idx_q;
    a_nxt   = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    sum_far = {1'b0, idx_q} + OFF_X;
    a_far   = (sum_far >= DEPTH_X) ? AW'(sum_far - DEPTH_X) : sum_far[AW-1:0];
    rd_en   = running & adv;
  end

  // Stage 3 (twist) feeds stage 4 (write-back select, in the top).
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      idx_q    <= '0;
      idx_rd   <= '0;
      v_rd     <= 1'b0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (adv) begin
      v_rd     <= running;
      idx_rd   <= idx_q;
      if (running) idx_q <= a_nxt;
      wb_valid <= v_rd;
      wb_addr  <= idx_rd;
      wb_data  <= twist_word(q_cur, q_nxt, q_far);
    end
  end
endmodule

// File: rtl/twister_rng.sv
module twister_rng
  import twister_pkg::*;
#(
  parameter int unsigned DEPTH  = 624,
  parameter int unsigned OFFSET = 397
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] seed_in,
  input  logic        seed_load,
  output logic [31:0] rnd_data,
  output logic        rnd_valid,
  input  logic        rnd_ready
);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned COPIES = 3;

  logic          adv;
  logic          s_we, running;
  logic [AW-1:0] s_addr;
  word_t         s_data;
  logic          rd_en;
  logic [AW-1:0] rd_addr [COPIES];
  word_t         rd_q    [COPIES];
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  word_t         wb_data;
  logic          m_we;
  logic [AW-1:0] m_addr;
  word_t         m_data;

  assign adv = ~rnd_valid | rnd_ready;

  twister_seed_ctl #(.DEPTH(DEPTH), .AW(AW)) u_seed (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_in),
    .wr_en(s_we), .wr_addr(s_addr), .wr_data(s_data), .running(running)
  );

  twister_update_pipe #(.DEPTH(DEPTH), .OFFSET(OFFSET), .AW(AW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flush(seed_load), .running(running), .adv(adv),
    .q_cur(rd_q[0]), .q_nxt(rd_q[1]), .q_far(rd_q[2]),
    .rd_en(rd_en), .a_cur(rd_addr[0]), .a_nxt(rd_addr[1]), .a_far(rd_addr[2]),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // Write-back select: the seeding port or the update pipeline.
  always_comb begin
    m_we   = s_we | (wb_valid & adv);
    m_addr = s_we ? s_addr : wb_addr;
    m_data = s_we ? s_data : wb_data;
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    twister_state_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr[c]), .rd_data(rd_q[c]),
      .wr_en(m_we), .wr_addr(m_addr), .wr_data(m_data)
    );
  end

  // Tempering output register, in step with the write-back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd_valid <= 1'b0;
      rnd_data  <= '0;
    end else if (seed_load) begin
      rnd_valid <= 1'b0;
    end else if (adv) begin
      rnd_valid <= wb_valid;
      if (wb_valid) rnd_data <= temper(wb_data);
    end
  end
endmodule

// File: rtl/twister_rng_chk.sv
module twister_rng_chk #(
  parameter int unsigned DEPTH = 624
) (
  input logic        clk,
  input logic        rst_n,
  input logic        seed_load,
  input logic [31:0] rnd_data,
  input logic        rnd_valid,
  input logic        rnd_ready
);
  localparam logic [15:0] LAT = 16'(DEPTH + 3);

  logic [15:0] since_load;
  logic        loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_load <= '0;
      loaded     <= 1'b0;
    end else if (seed_load) begin
      since_load <= '0;
      loaded     <= 1'b1;
    end else if (since_load < LAT) begin
      since_load <= since_load + 16'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !rnd_valid); // R1

  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> (loaded && since_load >= LAT)); // R2

  AST_STEADY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && rnd_ready && !seed_load) |=> rnd_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && !rnd_ready && !seed_load) |=> (rnd_valid && $stable(rnd_data))); // R8

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !rnd_valid); // R9
endmodule

bind twister_rng twister_rng_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .rnd_data(rnd_data),
  .rnd_valid(rnd_valid), .rnd_ready(rnd_ready)
);

// File: tb/tb_twister_rng.sv
module tb_twister_rng;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] seed_in = '0;
  logic        seed_load = 1'b0;
  logic [31:0] rnd_data;
  logic        rnd_valid;
  logic        rnd_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] rm [624];
  int          ri;

  always #5 clk = ~clk;

  twister_rng dut (
    .clk(clk), .rst_n(rst_n), .seed_in(seed_in), .seed_load(seed_load),
    .rnd_data(rnd_data), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 reference expansion
  task automatic ref_seed(input logic [31:0] s);
    rm[0] = s;
    for (int j = 1; j < 624; j++)
      rm[j] = 32'd1812433253 * (rm[j-1] ^ (rm[j-1] >> 30)) + 32'(j);
    ri = 0;
  endtask

  // R4 recurrence and R5 tempering
  task automatic ref_next(output logic [31:0] v);
    logic [31:0] y;
    y = {rm[ri][31], rm[(ri+1)%624][30:0]};
    rm[ri] = rm[(ri+397)%624] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
    y = rm[ri];
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & 32'h9D2C5680);
    y = y ^ ((y << 15) & 32'hEFC60000);
    y = y ^ (y >> 18);
    v = y;
    ri = (ri + 1) % 624;
  endtask

  // Pulse the strobe; returns at the falling edge after the strobe edge.
  task automatic pulse_load(input logic [31:0] s);
    @(negedge clk);
    seed_in   = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  // Count edges until valid (ready high); check latency and first word.
  task automatic wait_first(input string req);
    int k;
    logic [31:0] e;
    rnd_ready = 1'b1;
    k = 0;
    while (!rnd_valid && k < 800) begin
      @(negedge clk);
      k++;
    end
    check(k == 627, req, 32'(k), 32'd627);
    ref_next(e);
    check(rnd_data === e, "R3/R5 first word", rnd_data, e);
  endtask

  task automatic stream_full(input int n);
    logic [31:0] e;
    rnd_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rnd_valid === 1'b1, "R7 continuous valid", 32'(rnd_valid), 32'd1);
      ref_next(e);
      check(rnd_data === e, "R4 word", rnd_data, e);
    end
  endtask

  task automatic stream_stall(input int n);
    logic [31:0] e, held;
    bit was_stall;
    was_stall = 0;
    held = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (was_stall) begin
        check(rnd_valid === 1'b1, "R8 valid held", 32'(rnd_valid), 32'd1);
        check(rnd_data === held, "R8 data held", rnd_data, held);
      end
      rnd_ready = ((i % 3) != 1) && ((i % 7) != 5);
      if (rnd_valid && rnd_ready) begin
        ref_next(e);
        check(rnd_data === e, "R8 word after stalls", rnd_data, e);
        was_stall = 0;
      end else begin
        was_stall = rnd_valid;
        held = rnd_data;
      end
    end
    rnd_ready = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rnd_valid === 1'b0, "R1 after reset", 32'(rnd_valid), 32'd0);
    repeat (40) @(negedge clk);
    check(rnd_valid === 1'b0, "R1 idle without seed", 32'(rnd_valid), 32'd0);

    // R2, R6: known seed
    ref_seed(32'd5489);
    pulse_load(32'd5489);
    check(rnd_valid === 1'b0, "R2 low after strobe", 32'(rnd_valid), 32'd0);
    wait_first("R2 latency");
    check(rnd_data === 32'd3499211612, "R6 first word of 5489", rnd_data, 32'd3499211612);
    stream_full(1400);            // crosses the 624 wrap twice (R4, R7)
    stream_stall(900);            // R8

    // R9: reload while streaming
    ref_seed(32'd1);
    pulse_load(32'd1);
    check(rnd_valid === 1'b0, "R9 valid cleared", 32'(rnd_valid), 32'd0);
    wait_first("R9 restart latency");
    stream_full(700);

    // R10: strobe again during seeding
    pulse_load(32'd7);
    repeat (100) @(negedge clk);
    check(rnd_valid === 1'b0, "R10 still seeding", 32'(rnd_valid), 32'd0);
    ref_seed(32'h1234_5678);
    pulse_load(32'h1234_5678);
    wait_first("R10 latency from newer strobe");
    stream_full(300);

    // R3 edge: zero seed
    ref_seed(32'd0);
    pulse_load(32'd0);
    wait_first("R2 latency seed 0");
    stream_stall(400);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule